// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block turns single requests from a processor core into the pin-level timing of a multiplexed external memory bus of the kind found on small 8-bit controllers. One clock period of the block equals one oscillator period, and every strobe edge lands on a fixed period count inside the bus cycle. The low address byte and the data byte share one bus (`ad_out`/`ad_in` with an output enable), while the upper address bits have a port of their own.

A core raises `req_valid` with a kind code, a 16-bit address and write data while `req_ready` is high. The block then runs either a 7-period instruction fetch using the program-store strobe or a 12-period data access using the read or write strobe. It finishes with a one-period `done` pulse that carries the captured byte on `rdata`. A request presented during the final period of a cycle starts the next cycle with no gap.

Periods are numbered from 0, where period 0 is the clock period right after the edge that accepts a request. Kind codes: 0 is fetch, 1 is data read, 2 is data write, and 3 behaves as a data read.

Top module: `mxb_bus_seq`

## Requirements
- R1: While reset is held and after release with no request, `ale`=0, `psen_n`=1, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `done`=0 and `req_ready`=1.
- R2: `ale` is high in periods 0 and 1 of every cycle and low in all later periods of that cycle.
- R3: `ad_oe` is high with the low address byte on `ad_out` in periods 1 and 2. `addr_hi` shows the upper address byte in every period of the cycle.
- R4: A fetch (kind 0) drives `psen_n` low in periods 3 to 5 only and keeps `rd_n`/`wr_n` high. `ad_oe` is low in periods 0 and 3 to 6, and the cycle ends in period 6. `rdata` takes the `ad_in` value present at the end of period 5.
- R5: A read (kind 1 or 3) drives `rd_n` low in periods 5 to 10 only, with `ad_oe` low in periods 0 and 3 to 11. `rdata` takes the `ad_in` value present at the end of period 9.
- R6: A write (kind 2) drives `wr_n` low in periods 5 to 10 only. `ad_oe` is high with the write byte on `ad_out` in periods 4 to 11, and low in periods 0 and 3.
- R7: If `req_valid` is high during the final period of a cycle, `ale` is high in the very next period, which is period 0 of the new cycle.
- R8: `req_ready` is low from period 0 up to the period before the final one. Request inputs that change while it is low have no effect on `addr_hi` or on the cycle in progress.
- R9: `done` is high in exactly the final period (6 for a fetch, 11 for a data access), with `req_ready` high and, for fetch and read, the captured byte on `rdata`.
- R10: At no time are two of `psen_n`, `rd_n`, `wr_n` low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request strobe |
| req_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Request can be taken at the next edge |
| done | output | 1 | Final period of a bus cycle |
| rdata | output | 8 | Byte captured from the bus |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Shared bus, driven value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus, sampled value |
| addr_hi | output | 8 | Upper address byte |

## Verification
Directed fetch, read and write cycles are followed by a long stream of random kinds, addresses and write bytes. The bench compares every pin in every period with a per-kind timing table, so a strobe that is shifted or stretched by one period shows up, and so does a fetch that is handled as a data cycle. The memory model drives the bus only while a read strobe is low and returns an address-dependent byte, which exposes a wrong capture instant or a wrongly latched address. Requests chained in the final period, and inputs that change mid-cycle, separate correct back-to-back timing from a gap or a request taken too early.

// File: rtl/mxb_pkg.sv
package mxb_pkg;

    localparam logic [1:0] KIND_FETCH = 2'd0;
    localparam logic [1:0] KIND_WRITE = 2'd2;

    typedef struct packed {
        logic ale;
        logic psen_n;
        logic rd_n;
        logic wr_n;
        logic oe;
        logic sel_wdata;
        logic sample;
        logic fin;
    } strobe_t;

endpackage

// File: rtl/mxb_cycle_last.sv
module mxb_cycle_last #(
    parameter int FETCH_LAST = 6,
    parameter int DATA_LAST  = 11,
    parameter int CW         = 4
) (
    input  logic [1:0]    kind,
    output logic [CW-1:0] last
);
    localparam logic [CW-1:0] F_LAST = CW'(FETCH_LAST);
    localparam logic [CW-1:0] D_LAST = CW'(DATA_LAST);

    always_comb begin
        if (kind == mxb_pkg::KIND_FETCH) last = F_LAST;
        else                             last = D_LAST;
    end
endmodule

// File: rtl/mxb_strobe_decode.sv
module mxb_strobe_decode #(
    parameter int ALE_HI     = 2,
    parameter int PSEN_DLY   = 1,
    parameter int PSEN_LEN   = 3,
    parameter int DSTB_DLY   = 3,
    parameter int DSTB_LEN   = 6,
    parameter int WDATA_LEAD = 7,
    parameter int RD_SAMPLE  = 5,
    parameter int CW         = 4
) (
    input  logic             active,
    input  logic [1:0]       kind,
    input  logic [CW-1:0]    cnt,
    output mxb_pkg::strobe_t ctl
);
    localparam int ALE_FALL = ALE_HI;
    localparam int ADDR_ON  = ALE_FALL - 1;
    localparam int PSEN_ON  = ALE_FALL + PSEN_DLY;
    localparam int PSEN_OFF = PSEN_ON + PSEN_LEN;
    localparam int STB_ON   = ALE_FALL + DSTB_DLY;
    localparam int STB_OFF  = STB_ON + DSTB_LEN;
    localparam int WD_ON    = STB_OFF - WDATA_LEAD;
    localparam int F_SAMP   = PSEN_OFF - 1;
    localparam int D_SAMP   = STB_ON + RD_SAMPLE - 1;

    logic [CW-1:0] last;
    logic          is_fetch;
    logic          is_wr;
    logic          is_rd;
    int            v;

    mxb_cycle_last #(
        .FETCH_LAST (PSEN_OFF),
        .DATA_LAST  (STB_OFF),
        .CW         (CW)
    ) u_last (
        .kind (kind),
        .last (last)
    );

    function automatic logic in_win(int x, int lo, int hi_ex);
        return (x >= lo) && (x < hi_ex);
    endfunction

    always_comb begin
        v        = int'(cnt);
        is_fetch = (kind == mxb_pkg::KIND_FETCH);
        is_wr    = (kind == mxb_pkg::KIND_WRITE);
        is_rd    = !is_fetch && !is_wr;

        ctl.ale       = active && (v < ALE_FALL);
        ctl.psen_n    = !(active && is_fetch && in_win(v, PSEN_ON, PSEN_OFF));
        ctl.rd_n      = !(active && is_rd && in_win(v, STB_ON, STB_OFF));
        ctl.wr_n      = !(active && is_wr && in_win(v, STB_ON, STB_OFF));
        ctl.sel_wdata = active && is_wr && in_win(v, WD_ON, STB_OFF + 1);
        ctl.oe        = (active && in_win(v, ADDR_ON, ALE_FALL + 1)) || ctl.sel_wdata;
        ctl.sample    = active && ((is_fetch && (v == F_SAMP)) || (is_rd && (v == D_SAMP)));
        ctl.fin       = active && (cnt == last);
    end
endmodule

// File: rtl/mxb_bus_seq.sv
module mxb_bus_seq #(
    parameter int AW         = 16,
    parameter int DW         = 8,
    parameter int ALE_HI     = 2,
    parameter int PSEN_DLY   = 1,
    parameter int PSEN_LEN   = 3,
    parameter int DSTB_DLY   = 3,
    parameter int DSTB_LEN   = 6,
    parameter int WDATA_LEAD = 7,
    parameter int RD_SAMPLE  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          ale,
    output logic          psen_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    input  logic [DW-1:0] ad_in,
    output logic [AW-DW-1:0] addr_hi
);
    localparam int DATA_LAST = ALE_HI + DSTB_DLY + DSTB_LEN;
    localparam int CW        = $clog2(DATA_LAST + 1);
    localparam int HW        = AW - DW;

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [1:0]    kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } seq_t;

    typedef struct packed {
        mxb_pkg::strobe_t ctl;
        logic [DW-1:0]    ad;
        logic [HW-1:0]    hi;
        logic [DW-1:0]    rdata;
    } pin_t;

    seq_t             seq_d, seq_q;
    pin_t             pin_d, pin_q;
    mxb_pkg::strobe_t ctl_n;
    logic             take;

    localparam mxb_pkg::strobe_t CTL_IDLE = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1,
                                            wr_n: 1'b1, oe: 1'b0, sel_wdata: 1'b0,
                                            sample: 1'b0, fin: 1'b0};

    assign req_ready = !seq_q.busy || pin_q.ctl.fin;

    always_comb begin
        seq_d = seq_q;
        take  = req_ready && req_valid;
        if (take) begin
            seq_d.busy  = 1'b1;
            seq_d.cnt   = '0;
            seq_d.kind  = req_kind;
            seq_d.addr  = req_addr;
            seq_d.wdata = req_wdata;
        end else if (pin_q.ctl.fin) begin
            seq_d.busy = 1'b0;
        end else if (seq_q.busy) begin
            seq_d.cnt = seq_q.cnt + 1'b1;
        end
    end

    mxb_strobe_decode #(
        .ALE_HI     (ALE_HI),
        .PSEN_DLY   (PSEN_DLY),
        .PSEN_LEN   (PSEN_LEN),
        .DSTB_DLY   (DSTB_DLY),
        .DSTB_LEN   (DSTB_LEN),
        .WDATA_LEAD (WDATA_LEAD),
        .RD_SAMPLE  (RD_SAMPLE),
        .CW         (CW)
    ) u_dec (
        .active (seq_d.busy),
        .kind   (seq_d.kind),
        .cnt    (seq_d.cnt),
        .ctl    (ctl_n)
    );

    always_comb begin
        pin_d     = pin_q;
        pin_d.ctl = ctl_n;
        pin_d.hi  = seq_d.addr[AW-1:DW];
        if (ctl_n.sel_wdata)  pin_d.ad = seq_d.wdata;
        else if (ctl_n.oe)    pin_d.ad = seq_d.addr[DW-1:0];
        else                  pin_d.ad = '0;
        if (pin_q.ctl.sample) pin_d.rdata = ad_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= '0;
            pin_q       <= '0;
            pin_q.ctl   <= CTL_IDLE;
        end else begin
            seq_q <= seq_d;
            pin_q <= pin_d;
        end
    end

    assign done    = pin_q.ctl.fin;
    assign rdata   = pin_q.rdata;
    assign ale     = pin_q.ctl.ale;
    assign psen_n  = pin_q.ctl.psen_n;
    assign rd_n    = pin_q.ctl.rd_n;
    assign wr_n    = pin_q.ctl.wr_n;
    assign ad_out  = pin_q.ad;
    assign ad_oe   = pin_q.ctl.oe;
    assign addr_hi = pin_q.hi;
endmodule

// File: rtl/mxb_bus_seq_chk.sv
module mxb_bus_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ale,
    input logic psen_n,
    input logic rd_n,
    input logic wr_n,
    input logic ad_oe,
    input logic done,
    input logic req_ready
);
    a_r2_ale_two_periods: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |=> ale);

    a_r2_ale_not_three: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && $past(ale)) |=> !ale);

    a_r3_addr_around_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (ad_oe && $past(ad_oe)));

    a_r4_psen_three: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(psen_n) |=> !psen_n ##1 !psen_n ##1 psen_n);

    a_r5_bus_free_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    a_r6_bus_driven_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!psen_n, !rd_n, !wr_n}) <= 1);
endmodule

bind mxb_bus_seq mxb_bus_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ale       (ale),
    .psen_n    (psen_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ad_oe     (ad_oe),
    .done      (done),
    .req_ready (req_ready)
);

// File: tb/mxb_bus_seq_tb.sv
module mxb_bus_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        req_ready, done, ale, psen_n, rd_n, wr_n, ad_oe;
    logic [7:0]  rdata, ad_out, ad_in, addr_hi;
    logic [7:0]  lat_lo = 8'h0;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    mxb_bus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rdata(rdata), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
        .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi)
    );

    function automatic logic [7:0] mem_byte(logic [15:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'hC3;
    endfunction

    always @(negedge ale) lat_lo = ad_out;
    assign ad_in = (!psen_n || !rd_n) ? mem_byte({addr_hi, lat_lo})
                                      : ~mem_byte({addr_hi, lat_lo});

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int last_of(logic [1:0] k);
        return (k == 2'd0) ? 6 : 11;
    endfunction

    // Checks one whole bus cycle, starting just after the accepting edge.
    task automatic check_cycle(input logic [1:0] k, input logic [15:0] a, input logic [7:0] w,
                               input bit chain, input logic [1:0] nk,
                               input logic [15:0] na, input logic [7:0] nw);
        int  last = last_of(k);
        bit  f = (k == 2'd0);
        bit  wr = (k == 2'd2);
        bit  rd = !f && !wr;
        for (int p = 0; p <= last; p++) begin
            @(negedge clk);
            if (p == 0) begin
                req_valid = chain;
                req_kind  = nk;
                req_addr  = na;
                req_wdata = nw;
            end
            chk("R2 ale", 16'(ale), 16'(p < 2));
            chk(f ? "R4 psen_n" : "R4 psen_n idle in data cycle", 16'(psen_n),
                16'(!(f && p >= 3 && p <= 5)));
            chk("R5 rd_n", 16'(rd_n), 16'(!(rd && p >= 5 && p <= 10)));
            chk("R6 wr_n", 16'(wr_n), 16'(!(wr && p >= 5 && p <= 10)));
            chk("R3 R6 ad_oe", 16'(ad_oe), 16'((p == 1) || (p == 2) || (wr && p >= 4)));
            if (p == 1 || p == 2) chk("R3 low address", 16'(ad_out), 16'(a[7:0]));
            if (wr && p >= 4)     chk("R6 write data", 16'(ad_out), 16'(w));
            chk("R3 R8 addr_hi", 16'(addr_hi), 16'(a[15:8]));
            chk("R8 R9 req_ready", 16'(req_ready), 16'(p == last));
            chk("R9 done", 16'(done), 16'(p == last));
            chk("R10 strobes", 16'($countones({!psen_n, !rd_n, !wr_n}) <= 1), 16'd1);
            if (p == last && !wr)
                chk(f ? "R4 fetch rdata" : "R5 read rdata", 16'(rdata), 16'(mem_byte(a)));
        end
        if (!chain) begin
            @(negedge clk);
            chk("R1 idle after cycle", 16'({ale, psen_n, rd_n, wr_n, ad_oe, done, req_ready}),
                16'(7'b0111001));
        end else begin
            @(negedge clk);
            chk("R7 back-to-back ale", 16'(ale), 16'd1);
        end
    endtask

    task automatic start(input logic [1:0] k, input logic [15:0] a, input logic [7:0] w);
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = k;
        req_addr  = a;
        req_wdata = w;
        @(posedge clk);
    endtask

    // Runs a chained pair; the second request is accepted in the final period of the first.
    task automatic chained(input logic [1:0] k1, input logic [15:0] a1, input logic [7:0] w1,
                           input logic [1:0] k2, input logic [15:0] a2, input logic [7:0] w2);
        start(k1, a1, w1);
        check_cycle(k1, a1, w1, 1'b1, k2, a2, w2);
        // the R7 negedge was period 0 of the second cycle; finish the rest of it
        req_valid = 1'b0;
        req_addr  = ~a2;
        for (int p = 1; p <= last_of(k2); p++) begin
            @(negedge clk);
            chk("R7 second addr_hi", 16'(addr_hi), 16'(a2[15:8]));
            if (p == 1) chk("R7 second low address", 16'(ad_out), 16'(a2[7:0]));
            if (p == last_of(k2)) begin
                chk("R7 second done", 16'(done), 16'd1);
                if (k2 != 2'd2) chk("R7 second rdata", 16'(rdata), 16'(mem_byte(a2)));
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0]  k;
        logic [15:0] a;
        logic [7:0]  w;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset", 16'({ale, psen_n, rd_n, wr_n, ad_oe, done, req_ready}), 16'(7'b0111001));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", 16'({ale, psen_n, rd_n, wr_n, ad_oe, done, req_ready}),
            16'(7'b0111001));

        // directed corners
        start(2'd0, 16'h1234, 8'h00); check_cycle(2'd0, 16'h1234, 8'h00, 1'b0, 2'd2, 16'hFFFF, 8'hAA);
        start(2'd1, 16'hFF00, 8'h00); check_cycle(2'd1, 16'hFF00, 8'h00, 1'b0, 2'd0, 16'h0000, 8'h55);
        start(2'd2, 16'h00FF, 8'hA5); check_cycle(2'd2, 16'h00FF, 8'hA5, 1'b0, 2'd1, 16'h8001, 8'h00);
        start(2'd3, 16'h8001, 8'h00); check_cycle(2'd3, 16'h8001, 8'h00, 1'b0, 2'd0, 16'h7777, 8'h11);
        chained(2'd2, 16'h4321, 8'h3C, 2'd0, 16'hBEEF, 8'h00);
        chained(2'd0, 16'h0102, 8'h00, 2'd1, 16'hCAFE, 8'h00);
        chained(2'd1, 16'h5AA5, 8'h00, 2'd2, 16'h0F0F, 8'h81);

        // random traffic
        for (int i = 0; i < 60; i++) begin
            k = 2'($urandom_range(0, 3));
            a = 16'($urandom);
            w = 8'($urandom);
            if ($urandom_range(0, 3) == 0)
                chained(k, a, w, 2'($urandom_range(0, 3)), 16'($urandom), 8'($urandom));
            else begin
                start(k, a, w);
                check_cycle(k, a, w, 1'b0, 2'($urandom_range(0, 3)), 16'($urandom), 8'($urandom));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule